// File: doc/BRIEF.md
# PCM Frame Start and Bit Timing Aligner

This block sits at the edge of a PCM highway. It receives the highway data clock and an external frame-sync line, and it produces the internal timing that the serial logic needs. That timing has three parts: a one-cycle frame-start pulse, a strobe that marks the first clock of every bit period, and the index of the current bit within the frame. The sync line is never decoded directly. It is always sampled by the data clock, either on the falling edge or on the rising edge, and the choice is made by a configuration input. Only a low-to-high change of the sampled value starts a frame.

A rate input picks one of two bit timings. In single rate a bit lasts one clock. In double rate a bit lasts two clocks, and the half-bit phase is cleared at every frame start, so the bit grid always lines up with the frame boundary. A two-bit mode input selects how many highway ports are in use, and the block reports that count. In mode 2 double rate is not permitted. If double rate is requested in that mode, the block runs at single rate and raises an error flag.

The block runs entirely in the data-clock domain. Its configuration inputs are expected to stay static while frames are running.

Top module: `pcm_frame_aligner`

## Requirements
- R1: While reset is held, and with all inputs at 0, frameStart, bitStrobe, bitCount and rateError are all 0, and portCount is 4.
- R2: With syncEdge=1, fsyncIn is sampled at each rising clock edge. If the sample at rising edge k is 1 and the sample at edge k-1 was 0, frameStart is 1 for exactly the clock cycle that follows edge k.
- R3: With syncEdge=0, fsyncIn is sampled at each falling clock edge. A new high sample taken at the falling edge before rising edge k makes frameStart 1 for the cycle that follows edge k. As a result, a sync that rises between a falling edge and the next rising edge produces its frame start one cycle later than it would with syncEdge=1.
- R4: A sync input that stays high produces exactly one frameStart pulse. A further pulse needs a low sample first.
- R5: In single rate, bitStrobe is 1 on every cycle from the frame-start cycle onward. bitCount equals t mod BITS_PER_FRAME, where t is the number of cycles since the frame-start cycle (t=0 is that cycle).
- R6: In effective double rate, bitStrobe is 1 exactly when t is even, and bitCount equals (t/2) mod BITS_PER_FRAME, because the half-bit phase is cleared at frame start.
- R7: A frame start that arrives while a frame is running restarts the count: bitCount is 0 and bitStrobe is 1 in that cycle, whatever the previous count or phase was.
- R8: portCount is 4 for modeSel=0, 2 for modeSel=1, 1 for modeSel=2 and 2 for modeSel=3.
- R9: With modeSel=2 and dblRate=1, timing follows single rate (R5) and rateError is 1. In every other combination rateError is 0.
- R10: After reset and before the first frame start, bitStrobe is 0 and bitCount is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCM data clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fsyncIn | input | 1 | External frame-sync line |
| syncEdge | input | 1 | 0: sample sync on the falling clock edge; 1: sample on the rising clock edge |
| dblRate | input | 1 | 0: one clock per bit; 1: two clocks per bit |
| modeSel | input | 2 | Highway port-count mode |
| frameStart | output | 1 | One-cycle internal frame-start pulse |
| bitStrobe | output | 1 | High on the first clock of each bit period |
| bitCount | output | CNT_W | Bit index within the frame |
| portCount | output | 3 | Number of highway ports for the selected mode |
| rateError | output | 1 | Double rate was requested in mode 2 |

## Verification
A sync rise placed just after a falling edge yields frameStart in the cycle after the next rising edge when syncEdge=1, and one cycle later when syncEdge=0. The bench derives this latency from syncEdge before it drives the rise. It then reads every output 2 ns after each rising edge. From that reference cycle it computes the expected strobe and count arithmetically for each later cycle, using the effective bits-per-clock. portCount and rateError are combinational and are checked a few cycles after the configuration settles. The sweep covers every combination of sync edge, rate and mode, and each new frame start lands in a frame that is already running.

// File: rtl/pcm_align_pkg.sv
package pcm_align_pkg;

  // Strobes passed from the sync control to the bit-timing datapath
  typedef struct packed {
    logic frameStart;  // one-cycle internal frame start
    logic dblEff;      // double rate in effect (after mode restriction)
  } alignStrobe_t;

  function automatic logic [2:0] portsForMode(input logic [1:0] m);
    logic [2:0] n;
    case (m)
      2'd0:    n = 3'd4;
      2'd1:    n = 3'd2;
      2'd2:    n = 3'd1;
      default: n = 3'd2;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/pcm_fsync_ctrl.sv
module pcm_fsync_ctrl
  import pcm_align_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         fsyncIn,
  input  logic         syncEdge,
  input  logic         dblRate,
  input  logic [1:0]   modeSel,
  output alignStrobe_t strb,
  output logic [2:0]   portCount,
  output logic         rateError
);

  logic fallCap;    // sample taken on the falling edge
  logic fallXfer;   // falling sample moved onto the rising edge
  logic riseCap;    // sample taken on the rising edge
  logic prevSamp;   // selected sample one cycle earlier
  logic curSamp;
  logic modeLimit;

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) fallCap <= 1'b0;
    else       fallCap <= fsyncIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseCap  <= 1'b0;
      fallXfer <= 1'b0;
      prevSamp <= 1'b0;
    end else begin
      riseCap  <= fsyncIn;
      fallXfer <= fallCap;
      prevSamp <= curSamp;
    end
  end

  always_comb begin
    curSamp         = syncEdge ? riseCap : fallXfer;
    modeLimit       = (modeSel == 2'd2);
    strb.frameStart = curSamp & ~prevSamp;
    strb.dblEff     = dblRate & ~modeLimit;
    rateError       = dblRate & modeLimit;
    portCount       = portsForMode(modeSel);
  end

  // R4: a frame start is never followed directly by another one
  assert_one_start_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameStart |=> !strb.frameStart);

  // R2: a rise of the sync line seen at a rising edge gives a frame start in the next cycle
  assert_rise_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    (syncEdge && $past(syncEdge) && $rose(fsyncIn)) |=> strb.frameStart);

endmodule

// File: rtl/pcm_bit_datapath.sv
module pcm_bit_datapath
  import pcm_align_pkg::*;
#(
  parameter int BITS_PER_FRAME = 32,
  localparam int CNT_W = (BITS_PER_FRAME > 1) ? $clog2(BITS_PER_FRAME) : 1
)(
  input  logic             clk,
  input  logic             rstN,
  input  alignStrobe_t     strb,
  output logic             bitStrobe,
  output logic [CNT_W-1:0] bitCount
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS_PER_FRAME - 1);

  logic [CNT_W-1:0] cnt, curCnt;
  logic             ph, curPh;
  logic             running, active;

  always_comb begin
    curCnt    = strb.frameStart ? '0 : cnt;
    curPh     = strb.frameStart ? 1'b0 : ph;
    active    = strb.frameStart | running;
    bitStrobe = active & ~curPh;
    bitCount  = curCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      ph      <= 1'b0;
      running <= 1'b0;
    end else if (active) begin
      running <= 1'b1;
      if (strb.dblEff && !curPh) begin
        ph  <= 1'b1;
        cnt <= curCnt;
      end else begin
        ph  <= 1'b0;
        cnt <= (curCnt == LAST) ? '0 : curCnt + 1'b1;
      end
    end
  end

  // R5: the bit index never leaves the frame
  assert_count_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    bitCount <= LAST);

  // R6: the phase is cleared at frame start, so the second clock of bit 0 carries no strobe
  assert_phase_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.frameStart && strb.dblEff) |=> !bitStrobe);

  // R5: in steady single rate the index advances by one each cycle and wraps
  assert_single_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.frameStart && !strb.dblEff && $past(!strb.dblEff) && $past(active))
      |-> bitCount == (($past(bitCount) == LAST) ? '0 : $past(bitCount) + 1'b1));

endmodule

// File: rtl/pcm_frame_aligner.sv
module pcm_frame_aligner
  import pcm_align_pkg::*;
#(
  parameter int BITS_PER_FRAME = 32,
  localparam int CNT_W = (BITS_PER_FRAME > 1) ? $clog2(BITS_PER_FRAME) : 1
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             fsyncIn,
  input  logic             syncEdge,
  input  logic             dblRate,
  input  logic [1:0]       modeSel,
  output logic             frameStart,
  output logic             bitStrobe,
  output logic [CNT_W-1:0] bitCount,
  output logic [2:0]       portCount,
  output logic             rateError
);

  alignStrobe_t strb;

  pcm_fsync_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .fsyncIn   (fsyncIn),
    .syncEdge  (syncEdge),
    .dblRate   (dblRate),
    .modeSel   (modeSel),
    .strb      (strb),
    .portCount (portCount),
    .rateError (rateError)
  );

  pcm_bit_datapath #(.BITS_PER_FRAME(BITS_PER_FRAME)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .bitStrobe (bitStrobe),
    .bitCount  (bitCount)
  );

  assign frameStart = strb.frameStart;

  // R9: in mode 2 the double-rate strobe never reaches the datapath, and the error flag follows the request
  assert_mode2_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'd2) |-> (!strb.dblEff && (rateError == dblRate)));

endmodule

// File: tb/sim_pcm_frame_aligner.sv
module sim_pcm_frame_aligner;

  localparam int CLK_P = 10;
  localparam int BPF   = 8;
  localparam int CW    = $clog2(BPF);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          fsyncIn = 1'b0;
  logic          syncEdge = 1'b0;
  logic          dblRate = 1'b0;
  logic [1:0]    modeSel = 2'd0;
  logic          frameStart, bitStrobe, rateError;
  logic [CW-1:0] bitCount;
  logic [2:0]    portCount;

  int total = 0;
  int bad   = 0;

  pcm_frame_aligner #(.BITS_PER_FRAME(BPF)) u0 (
    .clk(clk), .rstN(rstN), .fsyncIn(fsyncIn), .syncEdge(syncEdge),
    .dblRate(dblRate), .modeSel(modeSel), .frameStart(frameStart),
    .bitStrobe(bitStrobe), .bitCount(bitCount), .portCount(portCount),
    .rateError(rateError)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int expPorts(input int m);
    case (m)
      0: return 4;
      1: return 2;
      2: return 1;
      default: return 2;
    endcase
  endfunction

  task automatic runOne(input int e, input int d, input int m);
    int lat, p, t;
    string sTag, cTag;
    @(negedge clk); #1;
    fsyncIn = 1'b0; syncEdge = e[0]; dblRate = d[0]; modeSel = m[1:0];
    repeat (4) @(posedge clk);
    #2;
    chk("R8", "portCount", int'(portCount), expPorts(m));
    chk("R9", "rateError", int'(rateError), (m == 2 && d == 1) ? 1 : 0);
    // rise just after a falling edge: separates the two sampling edges
    @(negedge clk); #1;
    fsyncIn = 1'b1;
    lat = e ? 0 : 1;
    p = (d == 1 && m != 2) ? 2 : 1;
    sTag = (m == 2 && d == 1) ? "R9" : ((p == 2) ? "R6" : "R5");
    for (int i = 0; i < 2 * BPF * p + lat + 3; i++) begin
      @(posedge clk); #2;
      t = i - lat;
      if (t < 0) begin
        chk("R3", "frameStart early", int'(frameStart), 0);
      end else begin
        if (t == 0) begin
          chk(e ? "R2" : "R3", "frameStart", int'(frameStart), 1);
          cTag = "R7";
        end else begin
          chk("R4", "frameStart held", int'(frameStart), 0);
          cTag = sTag;
        end
        chk(cTag, "bitStrobe", int'(bitStrobe), (t % p == 0) ? 1 : 0);
        chk(cTag, "bitCount", int'(bitCount), (t / p) % BPF);
      end
    end
    @(negedge clk); #1;
    fsyncIn = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++;
    total++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(3 * CLK_P + 2);
    chk("R1", "frameStart", int'(frameStart), 0);
    chk("R1", "bitStrobe", int'(bitStrobe), 0);
    chk("R1", "bitCount", int'(bitCount), 0);
    chk("R1", "rateError", int'(rateError), 0);
    chk("R1", "portCount", int'(portCount), 4);
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #2;
      chk("R10", "bitStrobe idle", int'(bitStrobe), 0);
      chk("R10", "bitCount idle", int'(bitCount), 0);
      chk("R10", "frameStart idle", int'(frameStart), 0);
    end
    for (int e = 0; e < 2; e++)
      for (int d = 0; d < 2; d++)
        for (int m = 0; m < 4; m++)
          runOne(e, d, m);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule